// File: doc/BRIEF.md
# Interleaved Video Output Multiplexer

This block sits at the output end of a video processing core. Each core sample carries four 13-bit components: luma, Cb, Cr and key. The block places them on four output ports, W, X, Y and Z, in one of three layouts chosen by a two-bit format field:

- **Separate:** three non-interleaved channels.
- **Luma plus chroma:** luma on one port and interleaved chroma on a second port.
- **Single stream:** one interleaved 4:2:2 stream on a single port.

The key always leaves on Z, aligned with the word it belongs to.

Core samples enter over a valid/ready stream. In the separate and luma-plus-chroma layouts the block takes one sample per clock and never applies back-pressure. In the single-stream layout every sample produces two output words, so the block accepts at most one sample every two clocks. It signals this by holding `in_ready` low for the cycle after each accepted sample. A sample moves only in a cycle where `in_valid` and `in_ready` are both high. The source must hold a sample and its `in_sync` bit stable until it is accepted.

The chroma phase comes from the `in_sync` bit that travels with each sample. The first accepted sample whose sync bit is low, following an accepted sample whose sync bit was high, starts a chroma pair; that sample supplies Cb and Cr for the pair. Output words stay invalid until the first such falling edge after reset. A later falling edge realigns the pairing.

An active-low output enable is turned into one drive-enable per port. This stands in for tri-state pads so the block can stay inside a larger synthesizable design.

Top module: `vomux_top`

## Requirements
- R1: With `cfg_fmt` = 2'b11, or the reserved value 2'b00, W carries luma, X carries Cb and Y carries Cr of the same sample. The words appear on the second rising edge, counting the edge that accepts the sample as the first.
- R2: With `cfg_fmt` = 2'b10, W carries luma and X carries the pair's Cb on a pair-start sample and the pair's Cr on the following sample. Y is held at zero. The latency is the same two edges as R1.
- R3: With `cfg_fmt` = 2'b01, W carries the repeating word order Cb, Y(first), Cr, Y(second). The Cb word appears on the fourth rising edge counting the accepting edge, and the words follow on consecutive clocks while samples arrive without gaps. X and Y are held at zero.
- R4: Z carries the key of the sample that supplied the luma in the same output slot. In the single-stream layout, both words produced from a sample carry that sample's key.
- R5: A pair starts on the first accepted sample with `in_sync` low after an accepted sample with `in_sync` high. Until the first such edge after reset, `out_valid` stays low and all data ports read zero. A later edge restarts the pairing at that sample, and the lock never drops before reset.
- R6: Cb and Cr of a pair are both taken from the pair-start sample. The second sample's Cb and Cr inputs have no effect on any output.
- R7: `in_ready` is high in every cycle for formats 2'b11, 2'b10 and 2'b00. In format 2'b01 it is low in the cycle that follows an accepted sample. A cycle without an accepted sample yields no output word: `out_valid` is low and the data ports read zero.
- R8: `w_oe`, `x_oe`, `y_oe` and `z_oe` are all high while `oe_n` is low and all low while `oe_n` is high. They follow `oe_n` without a clock.
- R9: While `rst_n` is low, `out_valid` and all data ports read zero, and `in_ready` is high in formats other than 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Output layout: 11 separate, 10 luma plus chroma, 01 single stream, 00 as 11 |
| oe_n | input | 1 | Active-low output enable |
| in_sync | input | 1 | Chroma phase marker carried with each sample |
| in_valid | input | 1 | Core sample present |
| in_ready | output | 1 | Block accepts the sample this cycle |
| in_luma | input | 13 | Core luma component |
| in_cb | input | 13 | Core Cb component |
| in_cr | input | 13 | Core Cr component |
| in_key | input | 13 | Core key component |
| w_data | output | 13 | Port W data |
| x_data | output | 13 | Port X data |
| y_data | output | 13 | Port Y data |
| z_data | output | 13 | Port Z data (key) |
| out_valid | output | 1 | Output ports carry a valid word this cycle |
| w_oe | output | 1 | Drive enable for port W |
| x_oe | output | 1 | Drive enable for port X |
| y_oe | output | 1 | Drive enable for port Y |
| z_oe | output | 1 | Drive enable for port Z |

## Verification
The bench drives inputs on falling edges, so a sample presented on one falling edge is accepted on the next rising edge. In the two parallel layouts that sample's words are therefore due on the second falling edge after it was presented. The bench compares every port against a table indexed by presentation cycle.

In the single-stream layout the bench logs the falling edge at which each accepted sample was presented. It expects the pair's first Cb exactly four falling edges later, with the rest of the word sequence following back to back. On the falling edge right after each acceptance it expects `in_ready` low.

The drive-enables have no clock, so the bench reads them one time unit after changing `oe_n`.

// File: rtl/vomux_pkg.sv
package vomux_pkg;
  typedef enum logic [1:0] {
    FMT_RSV = 2'b00,
    FMT_SER = 2'b01,
    FMT_YC  = 2'b10,
    FMT_SEP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    SL_IDLE   = 2'd0,
    SL_FIRST  = 2'd1,
    SL_SECOND = 2'd2
  } slot_e;
endpackage

// File: rtl/vomux_capture.sv
module vomux_capture #(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          in_sync,
  input  logic [DW-1:0] in_luma,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_key,
  output logic          s1_load,
  output logic          s1_lock,
  output logic [DW-1:0] s1_luma,
  output logic [DW-1:0] s1_cb,
  output logic [DW-1:0] s1_cr,
  output logic [DW-1:0] s1_chroma,
  output logic [DW-1:0] s1_key
);
  logic          sync_prev;
  logic          s1_even;
  logic [DW-1:0] held_cr;
  logic          fall;
  logic          next_even;

  // a low sync after a high one marks the pair-start sample
  assign fall      = sync_prev & ~in_sync;
  assign next_even = fall | ~s1_even;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev <= 1'b0;
      s1_even   <= 1'b1;
      s1_lock   <= 1'b0;
      s1_load   <= 1'b0;
      held_cr   <= '0;
      s1_luma   <= '0;
      s1_cb     <= '0;
      s1_cr     <= '0;
      s1_chroma <= '0;
      s1_key    <= '0;
    end else begin
      s1_load <= take;
      if (take) begin
        sync_prev <= in_sync;
        s1_even   <= next_even;
        if (fall) s1_lock <= 1'b1;
        s1_luma   <= in_luma;
        s1_cb     <= in_cb;
        s1_cr     <= in_cr;
        s1_key    <= in_key;
        // pair chroma comes only from the pair-start sample
        s1_chroma <= next_even ? in_cb : held_cr;
        if (next_even) held_cr <= in_cr;
      end
    end
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_lock |=> s1_lock);
endmodule

// File: rtl/vomux_serializer.sv
module vomux_serializer
  import vomux_pkg::*;
#(
  parameter int DW  = 13,
  parameter int PAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          take,
  input  logic          s1_lock,
  input  logic [DW-1:0] s1_luma,
  input  logic [DW-1:0] s1_chroma,
  input  logic [DW-1:0] s1_key,
  output logic          ser_vld,
  output logic [DW-1:0] ser_word,
  output logic [DW-1:0] ser_key
);
  localparam int NSTG = PAD + 1;

  slot_e         slot;
  logic          pv [NSTG];
  logic [DW-1:0] pw [NSTG];
  logic [DW-1:0] pk [NSTG];

  assign in_ready = (fmt != FMT_SER) || (slot != SL_FIRST);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= SL_IDLE;
    end else if (take) begin
      slot <= SL_FIRST;
    end else if (slot == SL_FIRST) begin
      slot <= SL_SECOND;
    end else begin
      slot <= SL_IDLE;
    end
  end

  // word generator: chroma in the first slot, luma in the second
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv[0] <= 1'b0;
      pw[0] <= '0;
      pk[0] <= '0;
    end else begin
      pv[0] <= (slot != SL_IDLE) && s1_lock;
      pw[0] <= (slot == SL_FIRST) ? s1_chroma : s1_luma;
      pk[0] <= s1_key;
    end
  end

  // padding stages that equalise the single-stream latency
  for (genvar k = 1; k < NSTG; k++) begin : g_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv[k] <= 1'b0;
        pw[k] <= '0;
        pk[k] <= '0;
      end else begin
        pv[k] <= pv[k-1];
        pw[k] <= pw[k-1];
        pk[k] <= pk[k-1];
      end
    end
  end

  assign ser_vld  = pv[NSTG-1];
  assign ser_word = pw[NSTG-1];
  assign ser_key  = pk[NSTG-1];

  // R7
  ser_ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_SER && take) |=> (fmt != FMT_SER || !in_ready));
endmodule

// File: rtl/vomux_drive.sv
module vomux_drive
  import vomux_pkg::*;
#(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          s1_load,
  input  logic          s1_lock,
  input  logic [DW-1:0] s1_luma,
  input  logic [DW-1:0] s1_cb,
  input  logic [DW-1:0] s1_cr,
  input  logic [DW-1:0] s1_chroma,
  input  logic [DW-1:0] s1_key,
  input  logic          ser_vld,
  input  logic [DW-1:0] ser_word,
  input  logic [DW-1:0] ser_key,
  output logic [DW-1:0] w_data,
  output logic [DW-1:0] x_data,
  output logic [DW-1:0] y_data,
  output logic [DW-1:0] z_data,
  output logic          out_valid
);
  logic          nv;
  logic [DW-1:0] nw, nx, ny, nz;

  always_comb begin
    case (fmt)
      FMT_SER: begin
        nv = ser_vld;
        nw = ser_word;
        nx = '0;
        ny = '0;
        nz = ser_key;
      end
      FMT_YC: begin
        nv = s1_load && s1_lock;
        nw = s1_luma;
        nx = s1_chroma;
        ny = '0;
        nz = s1_key;
      end
      default: begin
        nv = s1_load && s1_lock;
        nw = s1_luma;
        nx = s1_cb;
        ny = s1_cr;
        nz = s1_key;
      end
    endcase
    if (!nv) begin
      nw = '0;
      nx = '0;
      ny = '0;
      nz = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      w_data    <= '0;
      x_data    <= '0;
      y_data    <= '0;
      z_data    <= '0;
    end else begin
      out_valid <= nv;
      w_data    <= nw;
      x_data    <= nx;
      y_data    <= ny;
      z_data    <= nz;
    end
  end

  // R2
  yc_y_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt) == FMT_YC) |-> (y_data == '0));

  // R3
  ser_xy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt) == FMT_SER) |-> (x_data == '0 && y_data == '0));
endmodule

// File: rtl/vomux_top.sv
module vomux_top #(
  parameter int DW  = 13,
  parameter int PAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_fmt,
  input  logic          oe_n,
  input  logic          in_sync,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_luma,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_key,
  output logic [DW-1:0] w_data,
  output logic [DW-1:0] x_data,
  output logic [DW-1:0] y_data,
  output logic [DW-1:0] z_data,
  output logic          out_valid,
  output logic          w_oe,
  output logic          x_oe,
  output logic          y_oe,
  output logic          z_oe
);
  logic          take;
  logic          s1_load, s1_lock;
  logic [DW-1:0] s1_luma, s1_cb, s1_cr, s1_chroma, s1_key;
  logic          ser_vld;
  logic [DW-1:0] ser_word, ser_key;

  vomux_serializer #(.DW(DW), .PAD(PAD)) u_ser (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt),
    .in_valid(in_valid), .in_ready(in_ready), .take(take),
    .s1_lock(s1_lock), .s1_luma(s1_luma), .s1_chroma(s1_chroma), .s1_key(s1_key),
    .ser_vld(ser_vld), .ser_word(ser_word), .ser_key(ser_key)
  );

  vomux_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .in_sync(in_sync),
    .in_luma(in_luma), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
    .s1_load(s1_load), .s1_lock(s1_lock),
    .s1_luma(s1_luma), .s1_cb(s1_cb), .s1_cr(s1_cr),
    .s1_chroma(s1_chroma), .s1_key(s1_key)
  );

  vomux_drive #(.DW(DW)) u_drv (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt),
    .s1_load(s1_load), .s1_lock(s1_lock),
    .s1_luma(s1_luma), .s1_cb(s1_cb), .s1_cr(s1_cr),
    .s1_chroma(s1_chroma), .s1_key(s1_key),
    .ser_vld(ser_vld), .ser_word(ser_word), .ser_key(ser_key),
    .w_data(w_data), .x_data(x_data), .y_data(y_data), .z_data(z_data),
    .out_valid(out_valid)
  );

  // per-port drive enables stand in for pad tri-state control
  assign w_oe = ~oe_n;
  assign x_oe = ~oe_n;
  assign y_oe = ~oe_n;
  assign z_oe = ~oe_n;
endmodule

// File: tb/vomux_top_test.sv
module vomux_top_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_fmt;
  logic        oe_n, in_sync, in_valid, in_ready;
  logic [12:0] in_luma, in_cb, in_cr, in_key;
  logic [12:0] w_data, x_data, y_data, z_data;
  logic        out_valid, w_oe, x_oe, y_oe, z_oe;

  int n_chk = 0;
  int n_err = 0;

  // bench pairing model state
  logic        m_prev, m_even, m_lock;
  logic [12:0] m_hcr;

  logic        ev [32];
  logic [12:0] ew [32], ex [32], ey [32], ez [32];
  logic [12:0] sw [32], sk [32];

  vomux_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .oe_n(oe_n),
    .in_sync(in_sync), .in_valid(in_valid), .in_ready(in_ready),
    .in_luma(in_luma), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
    .w_data(w_data), .x_data(x_data), .y_data(y_data), .z_data(z_data),
    .out_valid(out_valid), .w_oe(w_oe), .x_oe(x_oe), .y_oe(y_oe), .z_oe(z_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [12:0] f_luma(input int i); return 13'h0400 + 13'(i); endfunction
  function automatic logic [12:0] f_cb(input int i);   return 13'h0800 + 13'(i); endfunction
  function automatic logic [12:0] f_cr(input int i);   return 13'h0C00 + 13'(i); endfunction
  function automatic logic [12:0] f_key(input int i);  return 13'h1000 + 13'(i); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic present(input int i, input logic s, input logic v);
    in_valid = v;
    in_sync  = s;
    in_luma  = f_luma(i);
    in_cb    = f_cb(i);
    in_cr    = f_cr(i);
    in_key   = f_key(i);
  endtask

  // pairing rule of R5/R6 applied to one accepted sample
  task automatic model_take(input int i, input logic s, output logic lock, output logic even,
                            output logic [12:0] chroma);
    logic fall;
    fall = m_prev & ~s;
    even = fall | ~m_even;
    if (fall) m_lock = 1'b1;
    chroma = even ? f_cb(i) : m_hcr;
    if (even) m_hcr = f_cr(i);
    m_even = even;
    m_prev = s;
    lock   = m_lock;
  endtask

  task automatic apply_reset(input logic [1:0] fmt, input logic chk_reset);
    rst_n = 1'b0;
    cfg_fmt = fmt;
    oe_n = 1'b0;
    present(0, 1'b0, 1'b0);
    m_prev = 1'b0; m_even = 1'b1; m_lock = 1'b0; m_hcr = '0;
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      check("R9 out_valid in reset", 32'(out_valid), 32'd0);
      check("R9 w_data in reset", 32'(w_data), 32'd0);
      check("R9 z_data in reset", 32'(z_data), 32'd0);
      check("R9 in_ready in reset", 32'(in_ready), 32'd1);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    check("R8 w_oe off", 32'(w_oe), 32'd0);
    check("R8 x_oe off", 32'(x_oe), 32'd0);
    check("R8 y_oe off", 32'(y_oe), 32'd0);
    check("R8 z_oe off", 32'(z_oe), 32'd0);
    oe_n = 1'b0; #1;
    check("R8 w_oe on", 32'(w_oe), 32'd1);
    check("R8 z_oe on", 32'(z_oe), 32'd1);
  endtask

  // parallel layouts: sample presented at falling edge c is due at falling edge c+2
  task automatic t_parallel(input logic [1:0] fmt, input int n, input int resync, input int gap,
                            input string tag);
    logic lk, evn;
    logic [12:0] ch;
    apply_reset(fmt, 1'b0);
    for (int c = 0; c < n + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check({tag, " out_valid"}, 32'(out_valid), 32'(ev[c-2]));
        check({tag, " w_data"},    32'(w_data),    32'(ew[c-2]));
        check({tag, " x_data"},    32'(x_data),    32'(ex[c-2]));
        check({tag, " y_data"},    32'(y_data),    32'(ey[c-2]));
        check({tag, " z_data (R4)"}, 32'(z_data),  32'(ez[c-2]));
      end
      if (c < n) begin
        logic s, v;
        s = (c == 0) || (c == resync - 1);
        v = (c != gap);
        present(c, s, v);
        #1;
        check({tag, " R7 in_ready"}, 32'(in_ready), 32'd1);
        ev[c] = 1'b0; ew[c] = '0; ex[c] = '0; ey[c] = '0; ez[c] = '0;
        if (v) begin
          model_take(c, s, lk, evn, ch);
          if (lk) begin
            ev[c] = 1'b1;
            ew[c] = f_luma(c);
            ex[c] = (fmt == 2'b10) ? ch : f_cb(c);
            ey[c] = (fmt == 2'b10) ? 13'd0 : f_cr(c);
            ez[c] = f_key(c);
          end
        end
      end else begin
        present(0, 1'b0, 1'b0);
      end
    end
  endtask

  // single-stream layout: Cb due four falling edges after the accepted presentation
  task automatic t_serial(input int n);
    logic lk, evn;
    logic [12:0] ch;
    int idx = 0, nw = 0, widx = 0;
    int first_exp = -1, first_seen = -1, last_acc = -10;
    apply_reset(2'b01, 1'b0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (last_acc == c - 1) check("R7 in_ready low after accept", 32'(in_ready), 32'd0);
      if (out_valid) begin
        if (first_seen < 0) first_seen = c;
        check("R3 x_data zero", 32'(x_data), 32'd0);
        check("R3 y_data zero", 32'(y_data), 32'd0);
        if (widx < nw) begin
          check("R3 w word order", 32'(w_data), 32'(sw[widx]));
          check("R4 z key per word", 32'(z_data), 32'(sk[widx]));
        end else begin
          check("R3 extra word", 32'(widx), 32'(nw));
        end
        widx++;
      end
      if (idx < n) begin
        present(idx, idx == 0, 1'b1);
        #1;
        if (in_ready) begin
          model_take(idx, idx == 0, lk, evn, ch);
          if (lk) begin
            sw[nw] = ch;          sk[nw] = f_key(idx); nw++;
            sw[nw] = f_luma(idx); sk[nw] = f_key(idx); nw++;
            if (first_exp < 0) first_exp = c + 4;
          end
          last_acc = c;
          idx++;
        end
      end else begin
        present(0, 1'b0, 1'b0);
      end
    end
    check("R3 latency of first Cb", 32'(first_seen), 32'(first_exp));
    check("R3 word count", 32'(widx), 32'(nw));
    check("R6 second Cr word is pair-start Cr", 32'(sw[2]), 32'(f_cr(1)));
  endtask

  initial begin
    #(CLK_P * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    apply_reset(2'b11, 1'b1);
    t_oe();
    // R1 R4 R5: separate layout, lock on first falling sync, gap at 4 (R7)
    t_parallel(2'b11, 10, -5, 4, "R1 sep");
    // R1: reserved code behaves as separate
    t_parallel(2'b00, 6, -5, -1, "R1 rsv");
    // R2 R6 R5: luma plus chroma, realign at sample 6, gap at 9 (R7)
    t_parallel(2'b10, 12, 6, 9, "R2 yc");
    // R3 R4 R7: single stream
    t_serial(9);
    summary();
    $finish;
  end
endmodule